// File: doc/BRIEF.md
# Configurable Memory Decoder with Access Traps

This block sits on a processor's memory bus and turns each access address into a select for one of three targets: a ROM region based at address zero, a RAM region based at 0x0200_0000, and a 256-byte register window based at 0x01F8_0000. The decoded ROM and RAM sizes come from a configuration register inside the window. After reset they are small: 4 KB of ROM and 256 KB of RAM. Software widens them by powers of two, up to 512 KB of ROM and 4 MB of RAM.

An access that hits none of the enabled regions gets no select. A trap pulse follows on the next cycle. The first failing address is captured in a register that software can read and rewrite.

An optional check limits RAM writes to two programmable block ranges. A control bit turns the check on.

Inside the window, the block holds its own control, configuration, segment and failing-address registers. Every other word offset is plain storage: it never traps and has no effect on decoding.

Top module: `memdec_trap`

## Requirements
- R1: While `acc_valid` is high, at most one select is asserted, in the same cycle as the access. `sel_rom` covers addresses from 0, `sel_ram` covers addresses from 0x0200_0000, and `sel_reg` covers 0x01F8_0000 to 0x01F8_00FF. All selects are low while `acc_valid` is low.
- R2: After reset, the decoder accepts only ROM addresses below 0x1000 and RAM addresses below 0x0204_0000. An access past either limit traps.
- R3: The configuration register at window offset 0x10 sets the sizes. Bits [2:0] hold the ROM code n, giving a size of 4 KB<<n, capped at 512 KB. Bits [10:8] hold the RAM code m, giving a size of 256 KB<<m, capped at 4 MB. All 32 bits read back as written, and the bits outside the two fields have no effect.
- R4: A valid access outside the enabled ROM, the enabled RAM and the window asserts no select in its cycle, and `trap` is high for exactly the following cycle. A valid access that is not faulting leaves `trap` low on the next cycle.
- R5: Any access inside the window never traps. A write to an offset other than 0x00, 0x10, 0x20, 0x24 or 0x30 is stored and reads back unchanged, and it does not change decoding.
- R6: Bit 3 of the control register at offset 0x00 enables write protection. A read of offset 0x00 returns bit 3 and zeros in every other bit.
- R7: The segment registers sit at offsets 0x20 and 0x24. In each one, bits [9:0] hold the first and bits [25:16] the last permitted 4 KB block, counted from the RAM base and inclusive at both ends. While protection is on, a RAM write whose block lies in neither segment traps and gets no select. RAM reads are never blocked.
- R8: The failing-address register at offset 0x30 captures the full address of the first trapping access, and `trap_addr` always shows it. Later traps leave it unchanged until software writes offset 0x30. That write loads the written value and re-arms the capture.
- R9: `reg_rdata` carries the addressed window word during a window read and is zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Write data for window writes |
| sel_rom | output | 1 | ROM selected |
| sel_ram | output | 1 | RAM selected |
| sel_reg | output | 1 | Register window selected |
| reg_rdata | output | 32 | Window read data |
| trap | output | 1 | Memory-exception pulse, one cycle after the faulting access |
| trap_addr | output | 32 | Contents of the failing-address register |

## Verification
A wrong size code or segment bound shows up in the same cycle as the access: a select drops that should be high, and one cycle later a trap appears that should not. For that reason the bench probes addresses one word on each side of every limit. A corrupted window word is invisible until it is read back, so the random mix interleaves window writes and reads. A capture flag stuck in the wrong state shows on `trap_addr` after the second trap following a re-arm.

// File: rtl/memdec_trap.sv
module memdec_trap #(
  parameter int          ROM_MIN_LG = 12,
  parameter int          ROM_MAX_LG = 19,
  parameter int          RAM_MIN_LG = 18,
  parameter int          RAM_MAX_LG = 22,
  parameter int          BLK_LG     = 12,
  parameter logic [31:0] RAM_BASE   = 32'h0200_0000,
  parameter logic [31:0] WIN_BASE   = 32'h01F8_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        sel_rom,
  output logic        sel_ram,
  output logic        sel_reg,
  output logic [31:0] reg_rdata,
  output logic        trap,
  output logic [31:0] trap_addr
);

  localparam int         WIN_WORDS = 64;
  localparam int         SEG_W     = RAM_MAX_LG - BLK_LG;
  localparam logic [5:0] CTRL_IDX  = 6'd0;
  localparam logic [5:0] CFG_IDX   = 6'd4;
  localparam logic [5:0] SEG0_IDX  = 6'd8;
  localparam logic [5:0] SEG1_IDX  = 6'd9;
  localparam logic [5:0] FFAR_IDX  = 6'd12;
  localparam int         PROT_BIT  = 3;

  logic [31:0]           regs [WIN_WORDS];
  logic [31:0]           ffar;
  logic                  ffar_held;
  logic                  trap_q;
  logic [5:0]            rom_lg, ram_lg;
  logic                  in_rom, in_ram, in_win;
  logic                  seg0_ok, seg1_ok, deny, fault;
  logic [31:0]           rd_word;

  wire [5:0]             widx    = acc_addr[7:2];
  wire [2:0]             rom_code = regs[CFG_IDX][2:0];
  wire [2:0]             ram_code = regs[CFG_IDX][10:8];
  wire [RAM_MAX_LG-1:0]  ram_off  = acc_addr[RAM_MAX_LG-1:0];
  wire [SEG_W-1:0]       blk      = acc_addr[RAM_MAX_LG-1:BLK_LG];
  wire                   prot_on  = regs[CTRL_IDX][PROT_BIT];

  always_comb begin
    rom_lg = 6'(ROM_MIN_LG) + 6'(rom_code);
    if (rom_lg > 6'(ROM_MAX_LG)) rom_lg = 6'(ROM_MAX_LG);
    ram_lg = 6'(RAM_MIN_LG) + 6'(ram_code);
    if (ram_lg > 6'(RAM_MAX_LG)) ram_lg = 6'(RAM_MAX_LG);
  end

  assign in_rom = (acc_addr >> rom_lg) == 32'd0;
  assign in_ram = (acc_addr[31:RAM_MAX_LG] == RAM_BASE[31:RAM_MAX_LG]) &&
                  ((ram_off >> ram_lg) == '0);
  assign in_win = acc_addr[31:8] == WIN_BASE[31:8];

  assign seg0_ok = (blk >= regs[SEG0_IDX][SEG_W-1:0]) &&
                   (blk <= regs[SEG0_IDX][16+SEG_W-1:16]);
  assign seg1_ok = (blk >= regs[SEG1_IDX][SEG_W-1:0]) &&
                   (blk <= regs[SEG1_IDX][16+SEG_W-1:16]);

  assign deny  = prot_on && acc_write && in_ram && !(seg0_ok || seg1_ok);
  assign fault = acc_valid && (!(in_rom || in_ram || in_win) || deny);

  assign sel_rom = acc_valid && in_rom && !fault;
  assign sel_ram = acc_valid && in_ram && !fault;
  assign sel_reg = acc_valid && in_win;

  always_comb begin
    if (widx == CTRL_IDX)      rd_word = {28'd0, prot_on, 3'd0};
    else if (widx == FFAR_IDX) rd_word = ffar;
    else                       rd_word = regs[widx];
  end

  assign reg_rdata = (sel_reg && !acc_write) ? rd_word : 32'd0;
  assign trap      = trap_q;
  assign trap_addr = ffar;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_WORDS; i++) regs[i] <= 32'd0;
      ffar      <= 32'd0;
      ffar_held <= 1'b0;
      trap_q    <= 1'b0;
    end else begin
      trap_q <= fault;
      if (sel_reg && acc_write) begin
        regs[widx] <= acc_wdata;
        if (widx == FFAR_IDX) begin
          ffar      <= acc_wdata;
          ffar_held <= 1'b0;
        end
      end
      if (fault && !ffar_held) begin
        ffar      <= acc_addr;
        ffar_held <= 1'b1;
      end
    end
  end

endmodule

module memdec_trap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [31:0] acc_addr,
  input logic        sel_rom,
  input logic        sel_ram,
  input logic        sel_reg,
  input logic [31:0] reg_rdata,
  input logic        trap,
  input logic [31:0] trap_addr
);

  wire any_sel = sel_rom || sel_ram || sel_reg;

  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom, sel_ram, sel_reg}));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !any_sel);

  a_r4_trap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !any_sel) |=> trap);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || any_sel) |=> !trap);

  a_r5_window_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[31:8] == 24'h01F800) |-> sel_reg);

  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && $past(trap)) |-> $stable(trap_addr));

  a_r9_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_reg && !acc_write) |-> reg_rdata == 32'd0);

endmodule

bind memdec_trap memdec_trap_chk u_chk (.*);

// File: tb/sim_memdec_trap.sv
`timescale 1ns/1ps
module sim_memdec_trap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = 32'd0, acc_wdata = 32'd0;
  logic        sel_rom, sel_ram, sel_reg, trap;
  logic [31:0] reg_rdata, trap_addr;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [31:0] m_regs [64];
  logic [31:0] m_ffar;
  logic        m_held;

  always #2 clk = ~clk;

  memdec_trap u0 (.*);

  function automatic bit f_win(input logic [31:0] a);
    return a[31:8] == 24'h01F800;
  endfunction

  function automatic bit f_rom(input logic [31:0] a);
    int lg = 12 + int'(m_regs[4][2:0]);
    if (lg > 19) lg = 19;
    return (a >> lg) == 32'd0;
  endfunction

  function automatic bit f_ram(input logic [31:0] a);
    int lg = 18 + int'(m_regs[4][10:8]);
    logic [31:0] off = a - 32'h0200_0000;
    if (lg > 22) lg = 22;
    return (a >= 32'h0200_0000) && ((off >> lg) == 32'd0);
  endfunction

  function automatic bit f_inseg(input logic [31:0] a, input logic [31:0] s);
    logic [9:0] b = a[21:12];
    return (b >= s[9:0]) && (b <= s[25:16]);
  endfunction

  function automatic bit f_fault(input bit w, input logic [31:0] a);
    bit ok = f_rom(a) || f_ram(a) || f_win(a);
    bit dn = m_regs[0][3] && w && f_ram(a) &&
             !(f_inseg(a, m_regs[8]) || f_inseg(a, m_regs[9]));
    return !ok || dn;
  endfunction

  function automatic logic [31:0] f_rd(input logic [31:0] a);
    logic [5:0] i = a[7:2];
    if (i == 6'd0)  return {28'd0, m_regs[0][3], 3'd0};
    if (i == 6'd12) return m_ffar;
    return m_regs[i];
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input bit v, input bit w, input logic [31:0] a,
                     input logic [31:0] d, input string tag);
    bit ef, er, em, eg;
    logic [31:0] ed;
    string t;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d;
    ef = v && f_fault(w, a);
    eg = v && f_win(a);
    er = v && !ef && f_rom(a);
    em = v && !ef && f_ram(a);
    ed = (eg && !w) ? f_rd(a) : 32'd0;
    if (tag != "") t = tag;
    else if (eg) t = "R5";
    else if (ef) t = "R4";
    else t = "R1";
    #1;
    check({t, " select"}, {29'd0, sel_rom, sel_ram, sel_reg}, {29'd0, er, em, eg});
    check({t, " rdata"}, reg_rdata, ed);
    @(posedge clk);
    if (eg && w) begin
      m_regs[a[7:2]] = d;
      if (a[7:2] == 6'd12) begin m_ffar = d; m_held = 1'b0; end
    end
    if (ef && !m_held) begin m_ffar = a; m_held = 1'b1; end
    #1;
    check({t, " trap"}, {31'd0, trap}, {31'd0, ef});
    check({t, " trap_addr"}, trap_addr, m_ffar);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_regs[i] = 32'd0;
    m_ffar = 32'd0; m_held = 1'b0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset selects", {29'd0, sel_rom, sel_ram, sel_reg}, 32'd0);
    check("R9 reset rdata", reg_rdata, 32'd0);
    check("R4 reset trap", {31'd0, trap}, 32'd0);
    check("R8 reset trap_addr", trap_addr, 32'd0);

    acc(1, 0, 32'h0000_0FFC, 0, "R2");
    acc(1, 0, 32'h0000_1000, 0, "R2");
    acc(1, 0, 32'h0203_FFFC, 0, "R2");
    acc(1, 1, 32'h0204_0000, 0, "R2");
    acc(1, 0, 32'h01F8_0030, 0, "R8");
    acc(1, 1, 32'h01F8_0030, 32'd0, "R8");
    acc(1, 0, 32'h1000_0000, 0, "R8");
    acc(1, 0, 32'h0300_0000, 0, "R8");
    acc(0, 0, 32'h1234_5678, 0, "R1");

    acc(1, 1, 32'h01F8_0010, 32'hFFFF_F302, "R3");
    acc(1, 0, 32'h01F8_0010, 0, "R3");
    acc(1, 0, 32'h0000_3FFC, 0, "R3");
    acc(1, 0, 32'h0000_4000, 0, "R3");
    acc(1, 0, 32'h021F_FFFC, 0, "R3");
    acc(1, 0, 32'h0220_0000, 0, "R3");
    acc(1, 1, 32'h01F8_0010, 32'h0000_0707, "R3");
    acc(1, 0, 32'h0007_FFFC, 0, "R3");
    acc(1, 0, 32'h0008_0000, 0, "R3");
    acc(1, 0, 32'h023F_FFFC, 0, "R3");
    acc(1, 0, 32'h0240_0000, 0, "R3");

    acc(1, 1, 32'h01F8_00FC, 32'hA5A5_1234, "R5");
    acc(1, 1, 32'h01F8_0044, 32'h0000_0707, "R5");
    acc(1, 0, 32'h01F8_00FC, 0, "R5");
    acc(1, 0, 32'h01F8_0044, 0, "R5");
    acc(1, 0, 32'h0007_FFFC, 0, "R5");

    acc(1, 1, 32'h01F8_0000, 32'hFFFF_FFF7, "R6");
    acc(1, 0, 32'h01F8_0000, 0, "R6");
    acc(1, 1, 32'h0210_0000, 0, "R6");
    acc(1, 1, 32'h01F8_0020, 32'h0010_0005, "R7");
    acc(1, 1, 32'h01F8_0024, 32'h03FF_03F0, "R7");
    acc(1, 1, 32'h01F8_0000, 32'h0000_0008, "R6");
    acc(1, 0, 32'h01F8_0000, 0, "R6");
    acc(1, 1, 32'h0200_5000, 0, "R7");
    acc(1, 1, 32'h0200_4FFC, 0, "R7");
    acc(1, 1, 32'h0201_0FFC, 0, "R7");
    acc(1, 1, 32'h0201_1000, 0, "R7");
    acc(1, 1, 32'h023F_0000, 0, "R7");
    acc(1, 0, 32'h0200_4000, 0, "R7");
    acc(1, 1, 32'h01F8_0030, 32'h0000_0000, "R8");
    acc(1, 1, 32'h0202_0000, 0, "R8");
    acc(1, 1, 32'h0202_0004, 0, "R8");
    acc(1, 0, 32'h01F8_0030, 0, "R8");
    acc(1, 1, 32'h01F8_0000, 32'h0, "R6");

    for (int n = 0; n < 4000; n++) begin
      int k = int'($urandom % 10);
      bit v = ($urandom % 8) != 0;
      bit w = $urandom % 2;
      logic [31:0] a;
      logic [31:0] d = $urandom;
      case (k)
        0, 1: a = $urandom % 32'h0009_0000;
        2, 3: a = 32'h0200_0000 + ($urandom % 32'h0048_0000);
        4, 5, 6: begin
          a = 32'h01F8_0000 | {24'd0, 6'($urandom), 2'b00};
          if (a[7:2] == 6'd4) d = d & 32'hFFFF_F7F7;
        end
        7: a = {$urandom} & 32'hFFFF_FFFC;
        8: a = (32'h1000 << ($urandom % 8)) - 32'd4 + ($urandom % 2) * 32'd4;
        default: a = 32'h0200_0000 + (32'h4_0000 << ($urandom % 5)) - 32'd4 +
                     ($urandom % 2) * 32'd4;
      endcase
      acc(v, w, a, d, "");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule